// File: doc/BRIEF.md
# Event Timer Compare Interrupt Unit

This unit keeps a free-running 24-bit event timer and four programmable 24-bit compare values. It latches events into a 16-bit sticky status word: compare hits, a wakeup from doze, an active-low attention pin, power-up completion, and completion pulses from the radio sequencer. A masked OR of the status word drives a single active-low interrupt line. Software reads the status word to learn what happened, and that read clears it.

Compare 2 is the busiest of the four. It gives a normal 24-bit match. While the doze flag is high, the same match also sets the doze status bit and issues a one-cycle wake pulse. When enabled, a separate 16-bit prime value matched against the low half of the timer sets the compare-2 status bit as well. Two status positions change meaning with a stream-mode configuration bit. In packet mode they report receive and transmit completion. In stream mode they report that a receive word is ready or that the transmitter needs a word.

All register access uses a simple synchronous bus. Writes take effect on the clock edge. Read data is combinational from the address. A status read clears the word on the edge that ends the read cycle.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset the timer is 0. Each cycle with `tick` high adds one to it, the value 0xFFFFFF wraps to 0, and the timer holds when `tick` is low.
- R2: A write to address 0 loads the timer and takes priority over a `tick` in the same cycle. A timer value reached by such a load never sets any compare, doze or timer status bit.
- R3: Compare 1, 3 and 4 sit at addresses 1, 3 and 4. They set status bits 8, 4 and 3 only on a `tick` that moves the timer onto the compare value. Writing a compare with the current timer value sets nothing.
- R4: Compare 2 (address 2) sets status bit 2 on a tick that moves the timer onto its 24-bit value. All four compares reset to 0.
- R5: Configuration is at address 6, with bit 0 the prime enable and bit 1 stream mode. The prime value is at address 5 and is 16 bits wide. When prime is enabled, a tick that moves timer bits 15:0 onto the prime value sets status bit 2. When prime is disabled, such a tick has no effect.
- R6: A 24-bit compare-2 hit while `dozeMode` is high sets status bit 9 together with bit 2, and raises `dozeWake` for exactly the following cycle. A prime-only hit, or any hit while `dozeMode` is low, leaves bit 9 and `dozeWake` at 0.
- R7: Status bit 10 is set on any cycle in which `attnN` is low, and on a `pwrUpDone` pulse.
- R8: With stream mode 0, `rxDone` sets bit 7 and `txDone` sets bit 6, while `rxWord` and `txWord` are ignored. With stream mode 1, the roles swap. `ccaDone` sets bit 5 in either mode.
- R9: Status bits are sticky. A read at address 8 with `regRe` high returns the current word and clears it on that edge. An event arriving in the same cycle as that read stays set.
- R10: `irqN` is low exactly when some status bit is set whose mask bit is also set. The mask is at address 7, is 16 bits wide, and resets to 0.
- R11: Addresses 0 to 7 read back the timer, the compares, the prime value, the two configuration bits and the mask, zero-extended to 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears status at address 8) |
| regAddr | input | 4 | Register address |
| regWdata | input | 24 | Write data |
| regRdata | output | 24 | Read data, combinational from address |
| tick | input | 1 | Timer advance enable |
| dozeMode | input | 1 | Unit is in doze mode |
| attnN | input | 1 | Attention pin, active low, synchronous |
| pwrUpDone | input | 1 | Power-up complete pulse |
| rxDone | input | 1 | Receive packet complete pulse |
| rxWord | input | 1 | Receive stream word ready pulse |
| txDone | input | 1 | Transmit packet sent pulse |
| txWord | input | 1 | Transmit stream word needed pulse |
| ccaDone | input | 1 | Channel assessment complete pulse |
| irqN | output | 1 | Interrupt, active low |
| dozeWake | output | 1 | One-cycle pulse returning from doze to idle |

## Verification
The hardest situation to reach from the ports is an event that arrives in the same cycle as the status read that clears the word. The bench reaches it by raising `ccaDone` in the very cycle it holds `regRe` at address 8. It then looks at the word without a clearing read to confirm the bit survived. Wrap, prime and doze hits normally need millions of ticks. The bench preloads the timer one or two steps short of each target, so every hit, including the reset-value compare hits at wrap, falls within a few cycles. It also confirms that preloads and compare rewrites onto the current value produce no hits.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int TMR_W   = 24;
  localparam int PRIME_W = 16;
  localparam int N_CMP   = 4;
  localparam int STAT_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int CFG_W   = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_TIMER    = addr_t'(0);
  localparam addr_t A_CMP_BASE = addr_t'(1);
  localparam addr_t A_PRIME    = addr_t'(5);
  localparam addr_t A_CFG      = addr_t'(6);
  localparam addr_t A_MASK     = addr_t'(7);
  localparam addr_t A_STAT     = addr_t'(8);

  localparam int CFG_PRIME  = 0;
  localparam int CFG_STREAM = 1;

  localparam int BIT_ATTN = 10;
  localparam int BIT_DOZE = 9;
  localparam int BIT_T1   = 8;
  localparam int BIT_RX   = 7;
  localparam int BIT_TX   = 6;
  localparam int BIT_CCA  = 5;
  localparam int BIT_T3   = 4;
  localparam int BIT_T4   = 3;
  localparam int BIT_T2   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrTimer;
    logic [N_CMP-1:0] wrCmp;
    logic             wrPrime;
  } dpStrobe_t;

  // hit reports from datapath to control
  typedef struct packed {
    logic [N_CMP-1:0] hit;
    logic             primeHit;
  } dpHit_t;
endpackage

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  logic [TMR_W-1:0]            wdata,
  input  dpStrobe_t                   strobe,
  output logic [TMR_W-1:0]            timerVal,
  output logic [N_CMP-1:0][TMR_W-1:0] cmpVal,
  output logic [PRIME_W-1:0]          primeVal,
  output dpHit_t                      hits
);
  logic [TMR_W-1:0] timerNext;
  logic             advance;

  assign timerNext = timerVal + TMR_W'(1);
  assign advance   = tick && !strobe.wrTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerVal <= '0;
    else if (strobe.wrTimer)  timerVal <= wdata;
    else if (tick)            timerVal <= timerNext;
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cmpVal[i] <= '0;
      else if (strobe.wrCmp[i]) cmpVal[i] <= wdata;
    end
    // a hit only when the timer steps onto the value
    assign hits.hit[i] = advance && (timerNext == cmpVal[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               primeVal <= '0;
    else if (strobe.wrPrime) primeVal <= wdata[PRIME_W-1:0];
  end

  assign hits.primeHit = advance && (timerNext[PRIME_W-1:0] == primeVal);
endmodule

// File: rtl/evt_control.sv
module evt_control
  import evt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWe,
  input  logic                        regRe,
  input  addr_t                       regAddr,
  input  logic [TMR_W-1:0]            regWdata,
  output logic [TMR_W-1:0]            regRdata,
  input  logic                        dozeMode,
  input  logic                        attnN,
  input  logic                        pwrUpDone,
  input  logic                        rxDone,
  input  logic                        rxWord,
  input  logic                        txDone,
  input  logic                        txWord,
  input  logic                        ccaDone,
  input  logic [TMR_W-1:0]            timerVal,
  input  logic [N_CMP-1:0][TMR_W-1:0] cmpVal,
  input  logic [PRIME_W-1:0]          primeVal,
  input  dpHit_t                      hits,
  output dpStrobe_t                   strobe,
  output logic [STAT_W-1:0]           statusWord,
  output logic [STAT_W-1:0]           maskWord,
  output logic                        dozeWake,
  output logic                        irqN
);
  logic [CFG_W-1:0]  cfgReg;
  logic [STAT_W-1:0] setVec;
  logic              statClr;
  logic              streamMode;
  logic              primeEn;
  logic              dozeHit;

  assign streamMode = cfgReg[CFG_STREAM];
  assign primeEn    = cfgReg[CFG_PRIME];
  assign statClr    = regRe && (regAddr == A_STAT);
  assign dozeHit    = hits.hit[1] && dozeMode;

  always_comb begin
    strobe.wrTimer = regWe && (regAddr == A_TIMER);
    strobe.wrPrime = regWe && (regAddr == A_PRIME);
    for (int i = 0; i < N_CMP; i++)
      strobe.wrCmp[i] = regWe && (regAddr == addr_t'(int'(A_CMP_BASE) + i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      maskWord <= '0;
    end else if (regWe) begin
      if (regAddr == A_CFG)  cfgReg   <= regWdata[CFG_W-1:0];
      if (regAddr == A_MASK) maskWord <= regWdata[STAT_W-1:0];
    end
  end

  always_comb begin
    setVec            = '0;
    setVec[BIT_ATTN]  = !attnN || pwrUpDone;
    setVec[BIT_DOZE]  = dozeHit;
    setVec[BIT_T1]    = hits.hit[0];
    setVec[BIT_RX]    = streamMode ? rxWord : rxDone;
    setVec[BIT_TX]    = streamMode ? txWord : txDone;
    setVec[BIT_CCA]   = ccaDone;
    setVec[BIT_T3]    = hits.hit[2];
    setVec[BIT_T4]    = hits.hit[3];
    setVec[BIT_T2]    = hits.hit[1] || (primeEn && hits.primeHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusWord <= '0;
      dozeWake   <= 1'b0;
    end else begin
      statusWord <= (statClr ? '0 : statusWord) | setVec;
      dozeWake   <= dozeHit;
    end
  end

  assign irqN = ~|(statusWord & maskWord);

  always_comb begin
    regRdata = '0;
    if (regAddr == A_TIMER) regRdata = timerVal;
    for (int i = 0; i < N_CMP; i++)
      if (regAddr == addr_t'(int'(A_CMP_BASE) + i)) regRdata = cmpVal[i];
    if (regAddr == A_PRIME) regRdata = TMR_W'(primeVal);
    if (regAddr == A_CFG)   regRdata = TMR_W'(cfgReg);
    if (regAddr == A_MASK)  regRdata = TMR_W'(maskWord);
    if (regAddr == A_STAT)  regRdata = TMR_W'(statusWord);
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TMR_W-1:0]  regWdata,
  output logic [TMR_W-1:0]  regRdata,
  input  logic              tick,
  input  logic              dozeMode,
  input  logic              attnN,
  input  logic              pwrUpDone,
  input  logic              rxDone,
  input  logic              rxWord,
  input  logic              txDone,
  input  logic              txWord,
  input  logic              ccaDone,
  output logic              irqN,
  output logic              dozeWake
);
  dpStrobe_t                   strobe;
  dpHit_t                      hits;
  logic [TMR_W-1:0]            timerVal;
  logic [N_CMP-1:0][TMR_W-1:0] cmpVal;
  logic [PRIME_W-1:0]          primeVal;
  logic [STAT_W-1:0]           statusWord;
  logic [STAT_W-1:0]           maskWord;

  evt_datapath u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wdata(regWdata), .strobe(strobe),
    .timerVal(timerVal), .cmpVal(cmpVal), .primeVal(primeVal), .hits(hits)
  );

  evt_control u_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dozeMode(dozeMode),
    .attnN(attnN), .pwrUpDone(pwrUpDone), .rxDone(rxDone), .rxWord(rxWord),
    .txDone(txDone), .txWord(txWord), .ccaDone(ccaDone),
    .timerVal(timerVal), .cmpVal(cmpVal), .primeVal(primeVal), .hits(hits),
    .strobe(strobe), .statusWord(statusWord), .maskWord(maskWord),
    .dozeWake(dozeWake), .irqN(irqN)
  );
endmodule

// File: rtl/evt_checker.sv
module evt_checker
  import evt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              dozeMode,
  input logic [TMR_W-1:0]  timerVal,
  input logic [STAT_W-1:0] statusWord,
  input logic              dozeWake,
  input logic              irqN
);
  localparam logic [STAT_W-1:0] TMR_BITS =
    STAT_W'((1 << BIT_T1) | (1 << BIT_T2) | (1 << BIT_T3) | (1 << BIT_T4) | (1 << BIT_DOZE));

  logic loadCyc;
  logic clrCyc;
  assign loadCyc = regWe && (regAddr == A_TIMER);
  assign clrCyc  = regRe && (regAddr == A_STAT);

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadCyc) |=> $stable(timerVal)); // R1

  AST_TIMER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !loadCyc && (timerVal == '1)) |=> (timerVal == '0)); // R1

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    loadCyc |=> ((statusWord & TMR_BITS) == ($past(statusWord) & TMR_BITS))); // R2

  AST_WAKE_DOZE: assert property (@(posedge clk) disable iff (!rstN)
    dozeWake |-> (statusWord[BIT_DOZE] && statusWord[BIT_T2] && $past(dozeMode))); // R6

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dozeWake |=> !dozeWake); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrCyc |=> ((statusWord & $past(statusWord)) == $past(statusWord))); // R9

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord == '0) |-> irqN); // R10
endmodule

bind evt_irq_unit evt_checker u_chk (.*);

// File: tb/evt_irq_unit_bench.sv
`timescale 1ns/1ps
module evt_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [23:0] regWdata = '0;
  logic [23:0] regRdata;
  logic        tick = 1'b0, dozeMode = 1'b0, attnN = 1'b1, pwrUpDone = 1'b0;
  logic        rxDone = 1'b0, rxWord = 1'b0, txDone = 1'b0, txWord = 1'b0, ccaDone = 1'b0;
  logic        irqN, dozeWake;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_unit u_evt_irq_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tick(tick), .dozeMode(dozeMode),
    .attnN(attnN), .pwrUpDone(pwrUpDone), .rxDone(rxDone), .rxWord(rxWord),
    .txDone(txDone), .txWord(txWord), .ccaDone(ccaDone),
    .irqN(irqN), .dozeWake(dozeWake)
  );

  task automatic chk(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [23:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdata;
  endtask

  task automatic readClr(output logic [23:0] d);
    @(negedge clk); regRe = 1'b1; regAddr = 4'd8; #1 d = regRdata;
    @(negedge clk); regRe = 1'b0;
  endtask

  task automatic doTick(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic testReset();
    logic [23:0] v;
    chk("R10", "irqN after reset", 24'(irqN), 24'd1);
    chk("R6", "dozeWake after reset", 24'(dozeWake), 24'd0);
    peek(4'd0, v); chk("R1", "timer after reset", v, 24'd0);
    peek(4'd8, v); chk("R9", "status after reset", v, 24'd0);
    peek(4'd7, v); chk("R10", "mask after reset", v, 24'd0);
  endtask

  task automatic testTimer();
    logic [23:0] v;
    doTick(5);
    peek(4'd0, v); chk("R1", "timer after 5 ticks", v, 24'd5);
    repeat (3) @(negedge clk);
    peek(4'd0, v); chk("R1", "timer holds without tick", v, 24'd5);
    wr(4'd0, 24'hFFFFFE);
    doTick(2);
    peek(4'd0, v); chk("R1", "timer wraps to 0", v, 24'd0);
    // all compares reset to 0, so the wrap hits timers 1..4
    readClr(v); chk("R4", "reset-value compares hit at wrap", v, 24'h00011C);
  endtask

  task automatic testCompares();
    logic [23:0] v;
    wr(4'd1, 24'h000010); wr(4'd2, 24'h900000);
    wr(4'd3, 24'h800000); wr(4'd4, 24'h700000);
    wr(4'd0, 24'h00000E);
    doTick(2);
    readClr(v); chk("R3", "compare 1 sets bit 8", v, 24'h000100);
    peek(4'd8, v); chk("R9", "status cleared by read", v, 24'h0);
    wr(4'd0, 24'h000020); wr(4'd3, 24'h000020);
    peek(4'd8, v); chk("R3", "rewrite compare to current timer", v, 24'h0);
    wr(4'd4, 24'h000030); wr(4'd0, 24'h000030);
    peek(4'd8, v); chk("R2", "preload onto compare value", v, 24'h0);
    wr(4'd0, 24'h00001F); doTick(1);
    readClr(v); chk("R3", "compare 3 sets bit 4", v, 24'h000010);
    wr(4'd0, 24'h00002F); doTick(1);
    readClr(v); chk("R3", "compare 4 sets bit 3", v, 24'h000008);
    // load and tick in the same cycle: load wins
    @(negedge clk); regWe = 1'b1; regAddr = 4'd0; regWdata = 24'h00002F; tick = 1'b1;
    @(negedge clk); regWe = 1'b0; tick = 1'b0;
    peek(4'd0, v); chk("R2", "load beats tick", v, 24'h00002F);
    peek(4'd8, v); chk("R2", "no hit from load", v, 24'h0);
  endtask

  task automatic testCmp2Prime();
    logic [23:0] v;
    wr(4'd2, 24'h123456); wr(4'd0, 24'h123455); doTick(1);
    chk("R6", "no wake outside doze", 24'(dozeWake), 24'd0);
    readClr(v); chk("R4", "compare 2 sets bit 2", v, 24'h000004);
    wr(4'd2, 24'hABCDEF); wr(4'd5, 24'h000100); wr(4'd6, 24'h0);
    wr(4'd0, 24'h7700FF); doTick(1);
    peek(4'd8, v); chk("R5", "prime disabled ignored", v, 24'h0);
    wr(4'd6, 24'h1); dozeMode = 1'b1;
    wr(4'd0, 24'h7700FF); doTick(1);
    chk("R6", "prime hit gives no wake", 24'(dozeWake), 24'd0);
    readClr(v); chk("R5", "prime enabled sets bit 2 only", v, 24'h000004);
    dozeMode = 1'b0; wr(4'd6, 24'h0);
  endtask

  task automatic testDoze();
    logic [23:0] v;
    wr(4'd2, 24'h000050); wr(4'd0, 24'h00004F);
    dozeMode = 1'b1;
    doTick(1);
    chk("R6", "dozeWake pulse", 24'(dozeWake), 24'd1);
    @(negedge clk);
    chk("R6", "dozeWake lasts one cycle", 24'(dozeWake), 24'd0);
    readClr(v); chk("R6", "doze sets bits 9 and 2", v, 24'h000204);
    dozeMode = 1'b0;
    wr(4'd0, 24'h00004F); doTick(1);
    readClr(v); chk("R6", "no doze bit when awake", v, 24'h000004);
  endtask

  task automatic testAttn();
    logic [23:0] v;
    @(negedge clk); attnN = 1'b0; @(negedge clk); attnN = 1'b1;
    readClr(v); chk("R7", "attention pin low", v, 24'h000400);
    @(negedge clk); pwrUpDone = 1'b1; @(negedge clk); pwrUpDone = 1'b0;
    readClr(v); chk("R7", "power-up done", v, 24'h000400);
  endtask

  task automatic testStream();
    logic [23:0] v;
    @(negedge clk); rxDone = 1'b1; @(negedge clk); rxDone = 1'b0;
    readClr(v); chk("R8", "packet mode rxDone", v, 24'h000080);
    @(negedge clk); rxWord = 1'b1; txWord = 1'b1; @(negedge clk); rxWord = 1'b0; txWord = 1'b0;
    peek(4'd8, v); chk("R8", "packet mode ignores word pulses", v, 24'h0);
    @(negedge clk); txDone = 1'b1; @(negedge clk); txDone = 1'b0;
    readClr(v); chk("R8", "packet mode txDone", v, 24'h000040);
    wr(4'd6, 24'h2);
    @(negedge clk); rxDone = 1'b1; txDone = 1'b1; @(negedge clk); rxDone = 1'b0; txDone = 1'b0;
    peek(4'd8, v); chk("R8", "stream mode ignores done pulses", v, 24'h0);
    @(negedge clk); rxWord = 1'b1; @(negedge clk); rxWord = 1'b0;
    readClr(v); chk("R8", "stream mode rxWord", v, 24'h000080);
    @(negedge clk); txWord = 1'b1; @(negedge clk); txWord = 1'b0;
    readClr(v); chk("R8", "stream mode txWord", v, 24'h000040);
    wr(4'd6, 24'h0);
  endtask

  task automatic testSticky();
    logic [23:0] v;
    @(negedge clk); ccaDone = 1'b1; @(negedge clk); ccaDone = 1'b0;
    repeat (3) @(negedge clk);
    peek(4'd8, v); chk("R9", "cca bit sticky", v, 24'h000020);
    // clearing read with a new event in the same cycle
    @(negedge clk); regRe = 1'b1; regAddr = 4'd8; ccaDone = 1'b1; #1 v = regRdata;
    @(negedge clk); regRe = 1'b0; ccaDone = 1'b0;
    chk("R9", "read returns pre-clear value", v, 24'h000020);
    peek(4'd8, v); chk("R9", "same-cycle event survives clear", v, 24'h000020);
    readClr(v);
    peek(4'd8, v); chk("R9", "cleared after plain read", v, 24'h0);
  endtask

  task automatic testIrq();
    logic [23:0] v;
    @(negedge clk); ccaDone = 1'b1; @(negedge clk); ccaDone = 1'b0;
    chk("R10", "masked status no irq", 24'(irqN), 24'd1);
    wr(4'h7, 24'h000020);
    chk("R10", "unmasked status irq", 24'(irqN), 24'd0);
    wr(4'h7, 24'h000040);
    chk("R10", "other mask bit no irq", 24'(irqN), 24'd1);
    wr(4'h7, 24'h000020);
    readClr(v);
    chk("R10", "irq released after clear", 24'(irqN), 24'd1);
    wr(4'h7, 24'h0);
  endtask

  task automatic testReadback();
    logic [23:0] v;
    wr(4'd1, 24'h111111); wr(4'd2, 24'h222222);
    wr(4'd3, 24'h333333); wr(4'd4, 24'h444444);
    wr(4'd5, 24'h12BEEF); wr(4'd6, 24'hFFFFFF); wr(4'd7, 24'hFFFFFF);
    wr(4'd0, 24'hABC123);
    peek(4'd0, v); chk("R11", "timer readback", v, 24'hABC123);
    peek(4'd1, v); chk("R11", "cmp1 readback", v, 24'h111111);
    peek(4'd2, v); chk("R11", "cmp2 readback", v, 24'h222222);
    peek(4'd3, v); chk("R11", "cmp3 readback", v, 24'h333333);
    peek(4'd4, v); chk("R11", "cmp4 readback", v, 24'h444444);
    peek(4'd5, v); chk("R11", "prime readback", v, 24'h00BEEF);
    peek(4'd6, v); chk("R11", "cfg readback", v, 24'h000003);
    peek(4'd7, v); chk("R11", "mask readback", v, 24'h00FFFF);
    wr(4'd6, 24'h0); wr(4'd7, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimer();
    testCompares();
    testCmp2Prime();
    testDoze();
    testAttn();
    testStream();
    testSticky();
    testIrq();
    testReadback();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule